// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host side of a two-wire programming link: a serial clock and a serial data line. It writes one block of code memory into a target whose memory is split into panels. Each panel has its own eight-byte write buffer. A single start request runs the whole sequence. The sequencer switches the target into configuration access and enables writes to every panel at once. It then returns to code-memory access. For each panel it points the target's table pointer at the panel address and loads four 16-bit words from a local data buffer. On the last panel it fires the programming cycle. Programming is timed from the host side: the fourth clock of a trailing no-op is stretched high for the program time and then held low for the discharge time.

Each transaction is a 4-bit command followed by a 16-bit payload, 20 clock pulses in all. Panel addresses are spaced a fixed power of two apart, starting from a base address. To program the next block, the host restarts in continue mode, which moves the base forward by eight bytes. The program and discharge durations are inputs given in system clock cycles. A one-cycle done pulse marks the end of the sequence.

Top module: `panel_prog_seq`

## Requirements
- R1: Each transaction is 20 pulses of ser_clk_o: 4 command bits, then 16 payload bits, each field least significant bit first. ser_dat_o changes only when ser_clk_o rises and holds through the falling edge. Every pulse is HALF_CYC cycles high and HALF_CYC cycles low, except those named in R6.
- R2: A sequence opens with 12 transactions: core (command 0x0) 0x8EA6, 0x8CA6, 0x86A6, 0x0E3C, 0x6EF8, 0x0E00, 0x6EF7, 0x0E06, 0x6EF6; then a plain write (command 0xC) of 0x0040; then core 0x8EA6 and 0x9CA6.
- R3: Each panel p opens with six core transactions: 0x0E<A[21:16]>, 0x6EF8, 0x0E<A[15:8]>, 0x6EF7, 0x0E<A[7:0]>, 0x6EF6. Here A = base + p*0x2000 and the upper byte is zero-extended.
- R4: Each panel then sends three incrementing writes (command 0xD) carrying buffer words 0, 1 and 2, then a final write carrying word 3. Buffer words are read through rd_panel_o and rd_word_o.
- R5: The final write uses command 0xC on every panel but the last. On the last panel it uses 0xF and is followed by a no-op (command 0x0, payload 0x0000).
- R6: In that no-op, the fourth pulse stays high for prog_cycles_i cycles and the low time after it lasts disch_cycles_i cycles. A value of 0 counts as 1.
- R7: busy_o rises in the cycle after an accepted start. After the no-op ends, done_o pulses high for exactly one cycle and busy_o falls. Each sequence gives exactly one done pulse.
- R8: start_i is ignored while busy_o is high. The running sequence continues unchanged.
- R9: A start with cont_i high uses the previous base plus 8 and ignores base_addr_i.
- R10: The number of panels written is panel_cnt_i, with 0 treated as 1 and values above PANEL_MAX treated as PANEL_MAX.
- R11: During and right after reset, ser_clk_o, ser_dat_o, busy_o and done_o are low. ser_clk_o is low whenever no transaction is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| cont_i | input | 1 | With start_i: continue at previous base + 8 |
| base_addr_i | input | ADDR_W | Address of panel 0 for a fresh start |
| panel_cnt_i | input | PCNT_W | Number of panels to write |
| prog_cycles_i | input | TW | Program hold time in cycles |
| disch_cycles_i | input | TW | Discharge hold time in cycles |
| rd_panel_o | output | PCNT_W | Panel index into the local data buffer |
| rd_word_o | output | 2 | Word index within that panel |
| rd_data_i | input | 16 | Buffer word, combinational response |
| ser_clk_o | output | 1 | Serial programming clock |
| ser_dat_o | output | 1 | Serial programming data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions assume two things about the inputs. rd_data_i must answer the current rd_panel_o and rd_word_o in the same cycle. The hold-time and panel-count inputs are treated as stable only at the points where they are sampled. The timer check also relies on the top module clamping the hold times to at least one cycle. The stimulus answers buffer reads through a combinational function of panel and word. It changes the hold-time inputs only while the block is idle. It drives start_i on the falling clock edge, including the stray starts and out-of-range counts that are meant to be ignored or clamped.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int CMD_W    = 4;
  localparam int PAY_W    = 16;
  localparam int FRM_W    = CMD_W + PAY_W;
  localparam int BIT_W    = $clog2(FRM_W);
  localparam int HOLD_BIT = 3;
  localparam int SETUP_N  = 12;
  localparam int PANEL_N  = 10;
  localparam int DATA_IDX = 6;

  typedef enum logic [3:0] {
    CMD_CORE   = 4'h0,
    CMD_WR     = 4'hC,
    CMD_WR_INC = 4'hD,
    CMD_WR_GO  = 4'hF
  } cmd_e;

  typedef enum logic [1:0] {PH_SETUP, PH_PANEL, PH_NOP} phase_e;

  function automatic logic [FRM_W-1:0] mk_frame(input logic [CMD_W-1:0] c,
                                                input logic [PAY_W-1:0] p);
    return {p, c};
  endfunction

  // Opening transactions: enable config access, multi-panel mode, back to code space.
  function automatic logic [FRM_W-1:0] setup_frame(input logic [3:0] i);
    case (i)
      4'd0:    return mk_frame(CMD_CORE, 16'h8EA6);
      4'd1:    return mk_frame(CMD_CORE, 16'h8CA6);
      4'd2:    return mk_frame(CMD_CORE, 16'h86A6);
      4'd3:    return mk_frame(CMD_CORE, 16'h0E3C);
      4'd4:    return mk_frame(CMD_CORE, 16'h6EF8);
      4'd5:    return mk_frame(CMD_CORE, 16'h0E00);
      4'd6:    return mk_frame(CMD_CORE, 16'h6EF7);
      4'd7:    return mk_frame(CMD_CORE, 16'h0E06);
      4'd8:    return mk_frame(CMD_CORE, 16'h6EF6);
      4'd9:    return mk_frame(CMD_WR,   16'h0040);
      4'd10:   return mk_frame(CMD_CORE, 16'h8EA6);
      default: return mk_frame(CMD_CORE, 16'h9CA6);
    endcase
  endfunction

  // Per-panel transactions: pointer load, three incrementing writes, final write.
  function automatic logic [FRM_W-1:0] panel_frame(input logic [3:0] i,
                                                   input logic [23:0] addr,
                                                   input logic [PAY_W-1:0] data,
                                                   input logic last);
    case (i)
      4'd0:    return mk_frame(CMD_CORE, {8'h0E, addr[23:16]});
      4'd1:    return mk_frame(CMD_CORE, 16'h6EF8);
      4'd2:    return mk_frame(CMD_CORE, {8'h0E, addr[15:8]});
      4'd3:    return mk_frame(CMD_CORE, 16'h6EF7);
      4'd4:    return mk_frame(CMD_CORE, {8'h0E, addr[7:0]});
      4'd5:    return mk_frame(CMD_CORE, 16'h6EF6);
      4'd6, 4'd7, 4'd8: return mk_frame(CMD_WR_INC, data);
      default: return mk_frame(last ? CMD_WR_GO : CMD_WR, data);
    endcase
  endfunction
endpackage

// File: rtl/pps_phase_timer.sv
module pps_phase_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len - TW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
  end

  assign expired = (cnt_q == '0);

  // R6: a phase length of zero would underflow; the top clamps hold times to 1.
  assert_len_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> len != '0);
endmodule

// File: rtl/pps_shifter.sv
module pps_shifter
  import pps_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int TW       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [FRM_W-1:0] frame,
  input  logic             stretch,
  input  logic [TW-1:0]    prog_len,
  input  logic [TW-1:0]    disch_len,
  output logic             ser_clk,
  output logic             ser_dat,
  output logic             frame_done
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRM_W - 1);
  localparam logic [BIT_W-1:0] HBIT     = BIT_W'(HOLD_BIT);
  localparam logic [BIT_W-1:0] PRE_HBIT = BIT_W'(HOLD_BIT - 1);
  localparam logic [TW-1:0]    HALF_LEN = TW'(HALF_CYC);

  typedef enum logic [1:0] {SH_IDLE, SH_HI, SH_LO} sh_e;

  sh_e              st_q;
  logic [BIT_W-1:0] bit_q;
  logic [FRM_W-1:0] frm_q;
  logic             str_q;
  logic             tmr_load, tmr_exp;
  logic [TW-1:0]    tmr_len;

  // Named events for the checks below.
  logic rise_ev, fall_ev, end_ev;
  assign fall_ev = (st_q == SH_HI) && tmr_exp;
  assign end_ev  = (st_q == SH_LO) && tmr_exp && (bit_q == LAST_BIT);
  assign rise_ev = ((st_q == SH_IDLE) && ld) ||
                   ((st_q == SH_LO) && tmr_exp && (bit_q != LAST_BIT));

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = HALF_LEN;
    unique case (st_q)
      SH_IDLE: tmr_load = ld;
      SH_HI: begin
        tmr_load = tmr_exp;
        if (str_q && bit_q == HBIT) tmr_len = disch_len;
      end
      SH_LO: begin
        tmr_load = tmr_exp && (bit_q != LAST_BIT);
        if (str_q && bit_q == PRE_HBIT) tmr_len = prog_len;
      end
      default: tmr_load = 1'b0;
    endcase
  end

  pps_phase_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= SH_IDLE;
      bit_q      <= '0;
      frm_q      <= '0;
      str_q      <= 1'b0;
      ser_clk    <= 1'b0;
      ser_dat    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= end_ev;
      unique case (st_q)
        SH_IDLE: if (ld) begin
          st_q    <= SH_HI;
          frm_q   <= frame;
          str_q   <= stretch;
          bit_q   <= '0;
          ser_clk <= 1'b1;
          ser_dat <= frame[0];
        end
        SH_HI: if (fall_ev) begin
          st_q    <= SH_LO;
          ser_clk <= 1'b0;
        end
        SH_LO: if (end_ev) begin
          st_q <= SH_IDLE;
        end else if (rise_ev) begin
          st_q    <= SH_HI;
          bit_q   <= bit_q + BIT_W'(1);
          ser_clk <= 1'b1;
          ser_dat <= frm_q[bit_q + BIT_W'(1)];
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  // R1: data moves only together with a rising serial clock.
  assert_dat_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ser_clk) |-> $stable(ser_dat));
  // R1: the controller never loads over a frame in flight.
  assert_load_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> st_q == SH_IDLE);
  // R11: no clock activity between frames.
  assert_clk_low_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SH_IDLE) |-> !ser_clk);
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int PANEL_MAX = 16,
  parameter int SPAN_LG   = 13,
  parameter int PCNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cont,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [PCNT_W-1:0] panel_cnt,
  input  logic [PAY_W-1:0]  rd_data,
  input  logic              sh_done,
  output logic              ld,
  output logic [FRM_W-1:0]  frame,
  output logic              stretch,
  output logic [PCNT_W-1:0] rd_panel,
  output logic [1:0]        rd_word,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {C_IDLE, C_LOAD, C_WAIT} cst_e;

  cst_e              st_q;
  phase_e            ph_q;
  logic [3:0]        idx_q;
  logic [PCNT_W-1:0] pnl_q, pcnt_q;
  logic [ADDR_W-1:0] base_q, pan_addr;
  logic              last_panel, accept;

  function automatic logic [PCNT_W-1:0] fit_count(input logic [PCNT_W-1:0] n);
    if (n == '0) return PCNT_W'(1);
    if (n > PCNT_W'(PANEL_MAX)) return PCNT_W'(PANEL_MAX);
    return n;
  endfunction

  function automatic logic [ADDR_W-1:0] panel_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [PCNT_W-1:0] p);
    return b + (ADDR_W'(p) << SPAN_LG);
  endfunction

  assign accept     = (st_q == C_IDLE) && start;
  assign last_panel = (pnl_q == pcnt_q - PCNT_W'(1));
  assign pan_addr   = panel_addr(base_q, pnl_q);
  assign rd_panel   = pnl_q;
  assign rd_word    = 2'(idx_q - 4'(DATA_IDX));
  assign stretch    = (ph_q == PH_NOP);
  assign ld         = (st_q == C_LOAD);
  assign busy       = (st_q != C_IDLE);

  always_comb begin
    unique case (ph_q)
      PH_SETUP: frame = setup_frame(idx_q);
      PH_PANEL: frame = panel_frame(idx_q, 24'(pan_addr), rd_data, last_panel);
      default:  frame = mk_frame(CMD_CORE, '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      ph_q   <= PH_SETUP;
      idx_q  <= '0;
      pnl_q  <= '0;
      pcnt_q <= PCNT_W'(1);
      base_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        C_IDLE: if (accept) begin
          base_q <= cont ? base_q + ADDR_W'(8) : base_addr;
          pcnt_q <= fit_count(panel_cnt);
          ph_q   <= PH_SETUP;
          idx_q  <= '0;
          pnl_q  <= '0;
          st_q   <= C_LOAD;
        end
        C_LOAD: st_q <= C_WAIT;
        C_WAIT: if (sh_done) begin
          st_q <= C_LOAD;
          unique case (ph_q)
            PH_SETUP: if (idx_q == 4'(SETUP_N - 1)) begin
              ph_q  <= PH_PANEL;
              idx_q <= '0;
            end else idx_q <= idx_q + 4'd1;
            PH_PANEL: if (idx_q == 4'(PANEL_N - 1)) begin
              idx_q <= '0;
              if (last_panel) ph_q <= PH_NOP;
              else            pnl_q <= pnl_q + PCNT_W'(1);
            end else idx_q <= idx_q + 4'd1;
            default: begin
              st_q <= C_IDLE;
              done <= 1'b1;
            end
          endcase
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  // R7: the end-of-sequence pulse lasts one cycle.
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: a start during a run leaves the latched run settings alone.
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(base_q) && $stable(pcnt_q)));
  // R10: the panel index stays inside the clamped count.
  assert_panel_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pnl_q < pcnt_q) && (pcnt_q != '0) && (pcnt_q <= PCNT_W'(PANEL_MAX)));
  // R5: the programming command is only sent for the final panel.
  assert_go_last_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && frame[CMD_W-1:0] == CMD_WR_GO) |-> (ph_q == PH_PANEL) && last_panel);
endmodule

// File: rtl/panel_prog_seq.sv
module panel_prog_seq
  import pps_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int PANEL_MAX = 16,
  parameter int SPAN_LG   = 13,
  parameter int HALF_CYC  = 2,
  parameter int TW        = 16,
  parameter int PCNT_W    = $clog2(PANEL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [PCNT_W-1:0] panel_cnt_i,
  input  logic [TW-1:0]     prog_cycles_i,
  input  logic [TW-1:0]     disch_cycles_i,
  output logic [PCNT_W-1:0] rd_panel_o,
  output logic [1:0]        rd_word_o,
  input  logic [PAY_W-1:0]  rd_data_i,
  output logic              ser_clk_o,
  output logic              ser_dat_o,
  output logic              busy_o,
  output logic              done_o
);
  logic             ld, stretch, sh_done;
  logic [FRM_W-1:0] frame;
  logic [TW-1:0]    prog_len, disch_len;

  assign prog_len  = (prog_cycles_i  == '0) ? TW'(1) : prog_cycles_i;
  assign disch_len = (disch_cycles_i == '0) ? TW'(1) : disch_cycles_i;

  pps_ctrl #(
    .ADDR_W(ADDR_W), .PANEL_MAX(PANEL_MAX), .SPAN_LG(SPAN_LG), .PCNT_W(PCNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .cont(cont_i),
    .base_addr(base_addr_i), .panel_cnt(panel_cnt_i), .rd_data(rd_data_i),
    .sh_done(sh_done), .ld(ld), .frame(frame), .stretch(stretch),
    .rd_panel(rd_panel_o), .rd_word(rd_word_o), .busy(busy_o), .done(done_o)
  );

  pps_shifter #(.HALF_CYC(HALF_CYC), .TW(TW)) u_shift (
    .clk(clk), .rst_n(rst_n), .ld(ld), .frame(frame), .stretch(stretch),
    .prog_len(prog_len), .disch_len(disch_len),
    .ser_clk(ser_clk_o), .ser_dat(ser_dat_o), .frame_done(sh_done)
  );
endmodule

// File: tb/sim_panel_prog_seq.sv
module sim_panel_prog_seq;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;

  logic        clk = 0, rst_n = 0;
  logic        start_i = 0, cont_i = 0;
  logic [21:0] base_addr_i = '0;
  logic [4:0]  panel_cnt_i = '0;
  logic [15:0] prog_cycles_i = '0, disch_cycles_i = '0;
  logic [4:0]  rd_panel_o;
  logic [1:0]  rd_word_o;
  logic [15:0] rd_data_i;
  logic        ser_clk_o, ser_dat_o, busy_o, done_o;

  int checks = 0, bad = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] bdata(input logic [4:0] p, input logic [1:0] w);
    return {4'hA, p[3:0], 6'b010101, w};
  endfunction
  assign rd_data_i = bdata(rd_panel_o, rd_word_o);

  panel_prog_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
    .base_addr_i(base_addr_i), .panel_cnt_i(panel_cnt_i),
    .prog_cycles_i(prog_cycles_i), .disch_cycles_i(disch_cycles_i),
    .rd_panel_o(rd_panel_o), .rd_word_o(rd_word_o), .rd_data_i(rd_data_i),
    .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o), .busy_o(busy_o), .done_o(done_o)
  );

  // Receiving monitor: decodes frames at falling serial clock edges.
  logic [3:0]  fcmd [256];
  logic [15:0] fpay [256];
  int          fhi3 [256], flo3 [256];
  bit          fbad [256];
  int nfr = 0, ndone = 0, mbit = 0, cnt = 0, cur_hi3 = 0, cur_lo3 = 0;
  bit prev = 0, dr = 0, cur_bad = 0;
  logic [19:0] sh = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mbit = 0; cnt = 0; prev = 0;
    end else begin
      if (ser_clk_o && !prev) begin
        if (mbit > 0) begin
          if (mbit - 1 == 3) cur_lo3 = cnt;
          else if (cnt != HALF) cur_bad = 1;
        end else cur_bad = 0;
        cnt = 1; dr = ser_dat_o;
      end else if (!ser_clk_o && prev) begin
        if (mbit == 3) cur_hi3 = cnt;
        else if (cnt != HALF) cur_bad = 1;
        if (ser_dat_o != dr) cur_bad = 1;
        sh[mbit] = ser_dat_o;
        mbit++; cnt = 1;
        if (mbit == 20) begin
          fcmd[nfr] = sh[3:0]; fpay[nfr] = sh[19:4];
          fhi3[nfr] = cur_hi3; flo3[nfr] = cur_lo3; fbad[nfr] = cur_bad;
          if (nfr < 255) nfr++;
          mbit = 0;
        end
      end else cnt++;
      prev = ser_clk_o;
      if (done_o) ndone++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected transaction list, restated from the requirements.
  logic [3:0]  ecmd [256];
  logic [15:0] epay [256];
  int ne = 0;

  task automatic push(input logic [3:0] c, input logic [15:0] p);
    ecmd[ne] = c; epay[ne] = p; ne++;
  endtask

  task automatic gen_exp(input logic [21:0] base, input int np);
    logic [21:0] a;
    ne = 0;
    push(0, 16'h8EA6); push(0, 16'h8CA6); push(0, 16'h86A6);
    push(0, 16'h0E3C); push(0, 16'h6EF8); push(0, 16'h0E00);
    push(0, 16'h6EF7); push(0, 16'h0E06); push(0, 16'h6EF6);
    push(4'hC, 16'h0040); push(0, 16'h8EA6); push(0, 16'h9CA6);
    for (int p = 0; p < np; p++) begin
      a = base + 22'(p * 8192);
      push(0, {8'h0E, 2'b00, a[21:16]}); push(0, 16'h6EF8);
      push(0, {8'h0E, a[15:8]});         push(0, 16'h6EF7);
      push(0, {8'h0E, a[7:0]});          push(0, 16'h6EF6);
      for (int w = 0; w < 3; w++) push(4'hD, bdata(5'(p), 2'(w)));
      push((p == np - 1) ? 4'hF : 4'hC, bdata(5'(p), 2'd3));
    end
    push(0, 16'h0000);
  endtask

  task automatic launch(input logic [21:0] b, input logic [4:0] n,
                        input logic [15:0] pr, input logic [15:0] ds, input logic c);
    @(negedge clk);
    nfr = 0; ndone = 0;
    base_addr_i = b; panel_cnt_i = n; prog_cycles_i = pr; disch_cycles_i = ds;
    cont_i = c; start_i = 1;
    @(negedge clk);
    start_i = 0; cont_i = 0;
  endtask

  task automatic wait_done();
    int w = 0;
    while (ndone == 0 && w < 40000) begin @(negedge clk); w++; end
    repeat (6) @(negedge clk);
  endtask

  task automatic check_run(input logic [21:0] base, input int np, input int pr, input int ds);
    string tag;
    int j;
    bit fmt_ok = 1;
    gen_exp(base, np);
    chk(nfr == ne, "R1", "transaction count", nfr, ne);
    for (int k = 0; k < ne && k < nfr; k++) begin
      if (k < 12) tag = "R2";
      else if (k == ne - 1) tag = "R5";
      else begin
        j = (k - 12) % 10;
        tag = (j < 6) ? "R3" : (j < 9) ? "R4" : "R5";
      end
      chk({fcmd[k], fpay[k]} == {ecmd[k], epay[k]}, tag, $sformatf("frame %0d", k),
          {fcmd[k], fpay[k]}, {ecmd[k], epay[k]});
      if (fbad[k]) fmt_ok = 0;
      if (k != ne - 1 && (fhi3[k] != HALF || flo3[k] != HALF)) fmt_ok = 0;
    end
    chk(fmt_ok, "R1", "pulse widths and data timing", fmt_ok, 1);
    if (nfr >= 1) begin
      chk(fhi3[nfr-1] == pr, "R6", "program hold", fhi3[nfr-1], pr);
      chk(flo3[nfr-1] == ds, "R6", "discharge hold", flo3[nfr-1], ds);
    end
    chk(ndone == 1, "R7", "done pulse count", ndone, 1);
    chk(busy_o == 0, "R7", "busy after done", busy_o, 0);
    chk(ser_clk_o == 0, "R11", "clock idle low", ser_clk_o, 0);
  endtask

  task automatic t_reset();
    chk({ser_clk_o, ser_dat_o, busy_o, done_o} == 0, "R11", "outputs in reset",
        {ser_clk_o, ser_dat_o, busy_o, done_o}, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    chk({ser_clk_o, ser_dat_o, busy_o, done_o} == 0, "R11", "outputs after reset",
        {ser_clk_o, ser_dat_o, busy_o, done_o}, 0);
  endtask

  task automatic t_basic();
    launch(22'h000010, 5'd3, 16'd37, 16'd11, 1'b0);
    chk(busy_o == 1, "R7", "busy after start", busy_o, 1);
    wait_done();
    check_run(22'h000010, 3, 37, 11);
  endtask

  task automatic t_continue();
    launch(22'h155555, 5'd2, 16'd9, 16'd4, 1'b1);  // R9: base input ignored
    wait_done();
    check_run(22'h000018, 2, 9, 4);
  endtask

  task automatic t_ignore();
    launch(22'h000100, 5'd2, 16'd6, 16'd5, 1'b0);
    repeat (300) @(negedge clk);
    base_addr_i = 22'h3F0000; panel_cnt_i = 5'd5; cont_i = 1; start_i = 1;  // R8
    @(negedge clk); start_i = 0; cont_i = 0;
    wait_done();
    check_run(22'h000100, 2, 6, 5);
  endtask

  task automatic t_clamp_low();
    launch(22'h002000, 5'd0, 16'd0, 16'd0, 1'b0);  // R10 zero panels, R6 zero holds
    wait_done();
    check_run(22'h002000, 1, 1, 1);
  endtask

  task automatic t_clamp_high();
    launch(22'h000000, 5'd20, 16'd5, 16'd3, 1'b0);  // R10 above maximum
    wait_done();
    check_run(22'h000000, 16, 5, 3);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_continue();
    t_ignore();
    t_clamp_low();
    t_clamp_high();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule